// File: doc/BRIEF.md
# SRAM Sleep-Mode Sequencer

This block controls power-down for a synchronous burst SRAM. An asynchronous, active-high sleep request is brought into the clock domain through a flop chain. The sequencer then moves through a fixed entry window, an asleep state, a fixed recovery window and a wait-for-load state. Afterwards it returns to normal operation. While the sequence runs, it gates new accesses off and forces the shared data bus to high impedance. The array contents are not touched.

The sequencer also checks how the host uses the protocol. It raises a one-cycle error pulse in three cases: sleep is requested while the device is selected, any chip enable goes active during recovery, or the first access after recovery tries to continue a burst instead of loading a fresh address. Any access that was in flight when sleep began is abandoned. The array is not modelled here. Only the cycle sequencing and the blocking are.

Top module: `sram_sleep_seq`

## Requirements
- R1: After synchronous reset, access_block, bus_hiz, sleeping and proto_err are all 0 and the sequencer is in normal operation.
- R2: A rise on sleep_in passes through SYNC_STAGES flops. access_block therefore first reads 1 after the (SYNC_STAGES+1)th rising clock edge that samples sleep_in high, and not earlier.
- R3: The entry window lasts exactly WIN_CYC cycles. In that window access_block and bus_hiz are 1 and sleeping is 0. After the window, sleeping reads 1, and whenever sleeping is 1, access_block is 1.
- R4: Once the synchronized request is low in the asleep state, sleeping drops to 0 and a recovery window of exactly WIN_CYC cycles follows. In the recovery window access_block stays 1. After it, access_block is 0 while bus_hiz stays 1.
- R5: If the synchronized request is seen high while sel is 1, in normal operation or while waiting for the first load, proto_err is 1 for the cycle after that edge.
- R6: sel at 1 on any edge of the recovery window gives proto_err 1 in the following cycle.
- R7: After recovery, adv=1 (continue burst) gives a proto_err pulse and leaves bus_hiz at 1. The first sel=1 with adv=0 (load) returns the block to normal operation, and bus_hiz reads 0 after that edge.
- R8: bus_hiz is 1 whenever access_block is 1. bus_hiz is also 1 in the wait-for-load state.
- R9: A request released during the entry window still completes the full window. The asleep state then lasts at least one cycle before recovery starts.
- R10: In normal operation, sel and adv have no effect. access_block, bus_hiz and proto_err stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sleep_in | input | 1 | Asynchronous sleep request, active high |
| sel | input | 1 | All chip enables active this cycle (decoded, active high) |
| adv | input | 1 | 1 = advance burst counter, 0 = load new address |
| access_block | output | 1 | Gate that blocks new accesses |
| bus_hiz | output | 1 | Forces the data bus to high impedance |
| sleeping | output | 1 | Low-power state reached |
| proto_err | output | 1 | One-cycle protocol-error pulse |

## Verification
The bench measures, cycle by cycle, how far the sleep request travels before the gate rises. A design that is one synchronizer stage short or long would move that edge. Both window lengths are timed exactly, so an off-by-one timer would show up as a window that is one cycle short or long. The bench also releases the request in the middle of the entry window. A design that aborts there would never reach the asleep state, or would skip it.

The error cases are driven on purpose:
- selecting during recovery;
- requesting sleep while selected;
- continuing a burst as the first access after recovery.

Each must produce a pulse, and the bus must stay tri-stated. A long run with pseudo-random inputs is then compared on every clock against a behavioural model.

// File: rtl/sleepseq_pkg.sv
package sleepseq_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE,
    ST_ENTER,
    ST_ASLEEP,
    ST_EXIT,
    ST_FIRST
  } seq_st_t;
endpackage

// File: rtl/sleep_sync_chain.sv
module sleep_sync_chain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/win_timer.sv
module win_timer #(
  parameter int WIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic last
);
  localparam int CW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(WIN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= '0;
    else if (run && !last) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_VAL);
endmodule

// File: rtl/sram_sleep_seq.sv
module sram_sleep_seq
  import sleepseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_CYC     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_in,
  input  logic sel,
  input  logic adv,
  output logic access_block,
  output logic bus_hiz,
  output logic sleeping,
  output logic proto_err
);
  seq_st_t st, st_nx;
  logic    ss;
  logic    win_last;
  logic    win_start;
  logic    win_run;
  logic    err_nx;

  sleep_sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (sleep_in),
    .q   (ss)
  );

  win_timer #(.WIN(WIN_CYC)) u_win (
    .clk   (clk),
    .rst   (rst),
    .start (win_start),
    .run   (win_run),
    .last  (win_last)
  );

  assign win_run = (st == ST_ENTER) || (st == ST_EXIT);

  always_comb begin
    st_nx     = st;
    win_start = 1'b0;
    case (st)
      ST_AWAKE: if (ss) begin
        st_nx = ST_ENTER; win_start = 1'b1;
      end
      ST_ENTER: if (win_last) st_nx = ST_ASLEEP;
      ST_ASLEEP: if (!ss) begin
        st_nx = ST_EXIT; win_start = 1'b1;
      end
      ST_EXIT: if (win_last) st_nx = ST_FIRST;
      ST_FIRST: begin
        if (ss) begin
          st_nx = ST_ENTER; win_start = 1'b1;
        end else if (sel && !adv) begin
          st_nx = ST_AWAKE;
        end
      end
      default: st_nx = ST_AWAKE;
    endcase
  end

  always_comb begin
    err_nx = 1'b0;
    if ((st == ST_AWAKE || st == ST_FIRST) && ss && sel) err_nx = 1'b1;
    if (st == ST_EXIT && sel)                            err_nx = 1'b1;
    if (st == ST_FIRST && !ss && adv)                    err_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_AWAKE;
      access_block <= 1'b0;
      bus_hiz      <= 1'b0;
      sleeping     <= 1'b0;
      proto_err    <= 1'b0;
    end else begin
      st           <= st_nx;
      access_block <= (st_nx == ST_ENTER) || (st_nx == ST_ASLEEP) || (st_nx == ST_EXIT);
      bus_hiz      <= (st_nx != ST_AWAKE);
      sleeping     <= (st_nx == ST_ASLEEP);
      proto_err    <= err_nx;
    end
  end

  // R2: the gate only rises after the synchronized request was high
  a_r2_rise_after_sync: assert property (@(posedge clk) disable iff (rst)
    $rose(access_block) |-> $past(ss));

  // R3: low-power state implies blocked accesses
  a_r3_sleep_blocked: assert property (@(posedge clk) disable iff (rst)
    sleeping |-> access_block);

  // R4: leaving the asleep state enters recovery with accesses still blocked
  a_r4_exit_blocked: assert property (@(posedge clk) disable iff (rst)
    $fell(sleeping) |-> access_block);

  // R5: sleep seen while selected raises the error pulse
  a_r5_sel_on_entry: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_AWAKE || st == ST_FIRST) && ss && sel) |=> proto_err);

  // R6: a chip enable active in recovery raises the error pulse
  a_r6_sel_in_exit: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXIT && sel) |=> proto_err);

  // R7: a burst continue as first access keeps the bus tri-stated
  a_r7_adv_first: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FIRST && !ss && adv) |=> (bus_hiz && !access_block && proto_err));

  // R8: blocked accesses always come with a tri-stated bus
  a_r8_hiz_covers: assert property (@(posedge clk) disable iff (rst)
    access_block |-> bus_hiz);
endmodule

// File: tb/sram_sleep_seq_test.sv
module sram_sleep_seq_test;
  localparam int SYNC = 2;
  localparam int WIN  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_in = 1'b0;
  logic sel = 1'b0;
  logic adv = 1'b0;
  logic access_block, bus_hiz, sleeping, proto_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sram_sleep_seq #(.SYNC_STAGES(SYNC), .WIN_CYC(WIN)) uut (
    .clk(clk), .rst(rst), .sleep_in(sleep_in), .sel(sel), .adv(adv),
    .access_block(access_block), .bus_hiz(bus_hiz),
    .sleeping(sleeping), .proto_err(proto_err)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 awake,1 entering,2 asleep,3 recovering,4 wait-load
  int  mphase = 0;
  int  mleft  = 0;
  bit  q[$];
  bit  e_blk = 0, e_hiz = 0, e_slp = 0, e_err = 0;
  bit  started = 0;

  always @(posedge clk) begin
    if (rst) begin
      mphase = 0; mleft = 0; q = {};
      for (int i = 0; i < SYNC; i++) q.push_back(1'b0);
      e_blk = 0; e_hiz = 0; e_slp = 0; e_err = 0;
      started = 1;
    end else begin
      bit s;
      s = q[0];
      e_err = ((mphase == 0 || mphase == 4) && s && sel) ||
              (mphase == 3 && sel) || (mphase == 4 && !s && adv);
      if (mphase == 0) begin
        if (s) begin mphase = 1; mleft = WIN; end
      end else if (mphase == 1) begin
        mleft--; if (mleft == 0) mphase = 2;
      end else if (mphase == 2) begin
        if (!s) begin mphase = 3; mleft = WIN; end
      end else if (mphase == 3) begin
        mleft--; if (mleft == 0) mphase = 4;
      end else begin
        if (s) begin mphase = 1; mleft = WIN; end
        else if (sel && !adv) mphase = 0;
      end
      void'(q.pop_front());
      q.push_back(sleep_in);
      e_blk = (mphase >= 1 && mphase <= 3);
      e_hiz = (mphase != 0);
      e_slp = (mphase == 2);
    end
  end

  always @(negedge clk) begin
    if (started && !done) begin
      chk("R3", "access_block", access_block, e_blk);
      chk("R8", "bus_hiz", bus_hiz, e_hiz);
      chk("R4", "sleeping", sleeping, e_slp);
      chk("R5", "proto_err", proto_err, e_err);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    chk("R1", "reset access_block", access_block, 1'b0);
    chk("R1", "reset bus_hiz", bus_hiz, 1'b0);
    chk("R1", "reset sleeping", sleeping, 1'b0);
    chk("R1", "reset proto_err", proto_err, 1'b0);

    // R10: traffic in normal operation has no effect
    sel = 1; adv = 0; cyc(2);
    adv = 1; cyc(2);
    chk("R10", "block while awake", access_block, 1'b0);
    chk("R10", "hiz while awake", bus_hiz, 1'b0);
    chk("R10", "err while awake", proto_err, 1'b0);
    sel = 0; adv = 0;

    // R2 / R3: entry latency and window
    sleep_in = 1;
    cyc(SYNC);
    chk("R2", "block before sync", access_block, 1'b0);
    cyc(1);
    chk("R2", "block after sync", access_block, 1'b1);
    chk("R3", "entry not asleep", sleeping, 1'b0);
    chk("R3", "entry hiz", bus_hiz, 1'b1);
    cyc(WIN - 1);
    chk("R3", "entry still not asleep", sleeping, 1'b0);
    cyc(1);
    chk("R3", "asleep after window", sleeping, 1'b1);
    cyc(5);

    // R4 / R6: recovery
    sleep_in = 0;
    cyc(SYNC + 1);
    chk("R4", "sleeping dropped", sleeping, 1'b0);
    chk("R4", "recovery blocked", access_block, 1'b1);
    sel = 1; cyc(1);
    chk("R6", "sel in recovery flags", proto_err, 1'b1);
    chk("R4", "recovery still blocked", access_block, 1'b1);
    sel = 0; cyc(WIN - 1);
    chk("R4", "gate open after recovery", access_block, 1'b0);
    chk("R4", "bus held tri-stated", bus_hiz, 1'b1);

    // R7: burst continue rejected, load accepted
    adv = 1; cyc(1);
    chk("R7", "advance flags", proto_err, 1'b1);
    chk("R7", "advance keeps hiz", bus_hiz, 1'b1);
    adv = 0; sel = 1; cyc(1);
    chk("R7", "load releases bus", bus_hiz, 1'b0);
    chk("R7", "load no error", proto_err, 1'b0);

    // R5 / R9: sleep while selected, released inside entry window
    sleep_in = 1;
    cyc(SYNC + 1);
    chk("R5", "sleep while selected", proto_err, 1'b1);
    sel = 0; sleep_in = 0;
    cyc(1);
    chk("R5", "pulse single cycle", proto_err, 1'b0);
    chk("R9", "entry continues", sleeping, 1'b0);
    cyc(WIN - 1);
    chk("R9", "asleep reached", sleeping, 1'b1);
    cyc(1);
    chk("R9", "asleep one cycle then recovery", sleeping, 1'b0);
    chk("R9", "recovery blocked", access_block, 1'b1);
    cyc(WIN + 1);
    sel = 1; cyc(1); sel = 0;
    chk("R7", "back to normal", bus_hiz, 1'b0);

    // Mixed traffic checked by the reference model
    for (int i = 0; i < 400; i++) begin
      if (i % 37 == 0) sleep_in = ~sleep_in;
      sel = ($urandom % 4) == 0;
      adv = ($urandom % 3) == 0;
      cyc(1);
    end
    sel = 0; adv = 0; sleep_in = 0;
    cyc(10);
    finish_run();
  end
endmodule